// File: doc/BRIEF.md
# Answering Machine Call Controller

This block takes the telephone line for an answering machine. While idle it waits in a monitoring phase. An external ring counter reports that enough rings have arrived, and the controller then goes off-hook and runs the answer sequence. The sequence plays the announcement, sounds a one-second beep, records the caller, sounds a closing beep, counts the stored message and hangs up. After that it returns to monitoring.

Several events can cut the sequence short, and they are ranked. If the machine is switched off during any answering step, the controller drops straight back to monitoring. The remote-access tone sends the controller to remote operation, and this wins over a hangup that arrives in the same cycle. A caller who hangs up during the announcement or the opening beep gets no recording. A hangup during recording is the normal way a message ends. The other units supply a one-second tick and done strobes. Audio handling and tone decoding are done elsewhere.

Top module: `call_ctrl`

## Requirements
- R1: After reset the line is on-hook. `play_en`, `beep_en`, `rec_en` and `remote_start` are low, and `msg_count` is zero.
- R2: A `ring_done` pulse while monitoring, with `line_hangup` low, sets `off_hook` and `play_en` high from the next cycle on.
- R3: A `ring_done` pulse while monitoring has no effect if `line_hangup` is high in the same cycle. The line stays on-hook and monitoring starts over.
- R4: Each answering step starts when the one before it completes:
  - `ann_done` during play starts the opening beep.
  - The next `sec_tick` starts recording.
  - After recording comes the closing beep.
  - The next `sec_tick` starts the hang-up step. This step lasts exactly one cycle with `off_hook` low, and monitoring follows.
- R5: A hangup during the announcement goes to the hang-up step. It skips both beeps and the recording, and `msg_count` does not change.
- R6: Tone code 4'b0001 during the announcement, the opening beep or recording enters remote operation. `off_hook` stays high and `remote_start` is high for exactly one cycle. `remote_done` then leads to the hang-up step. Any other tone code is ignored.
- R7: If tone code 4'b0001 and `line_hangup` are both present in the same cycle, remote operation is taken.
- R8: A falling edge of `machine_on` in any answering step returns the controller to monitoring on the next cycle. The message count is not incremented.
- R9: `msg_count` rises by one when the closing beep completes. A hangup during the opening beep goes to the hang-up step without counting. A hangup during the closing beep is ignored.
- R10: `msg_count` holds at its all-ones value instead of wrapping.
- R11: Recording ends by itself on the `REC_LIMIT`-th `sec_tick` counted from the start of recording, even if the caller stays on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_done | input | 1 | Pulse: required ring count reached |
| line_hangup | input | 1 | Level: caller has hung up |
| machine_on | input | 1 | Level: machine switched on |
| tone_code | input | 4 | Decoded button-tone code |
| sec_tick | input | 1 | One-cycle pulse every second |
| ann_done | input | 1 | Announcement player finished |
| remote_done | input | 1 | Remote-operation unit finished |
| off_hook | output | 1 | Line held off-hook |
| play_en | output | 1 | Announcement playback enable |
| beep_en | output | 1 | Beep enable |
| rec_en | output | 1 | Message recording enable |
| remote_start | output | 1 | One-cycle start pulse for remote operation |
| msg_count | output | CNT_W | Stored message count, saturating |

## Verification
Complete calls are driven in two ways:
- ended by a caller hangup, and
- ended by the recording limit.

This separates the two ways recording can complete and confirms both of them count.

Each preempting event is applied in every step where it matters:
- A hangup is applied while monitoring, during the announcement, during each beep and during recording. This tells abort, restart and normal completion apart.
- The remote tone is applied alone, together with a hangup, and with a wrong code.
- A switch-off is applied during recording and during remote operation.

A long run of calls drives the counter into saturation.

// File: rtl/call_ctrl_pkg.sv
package call_ctrl_pkg;

    localparam int TONE_W = 4;
    localparam logic [TONE_W-1:0] TONE_REMOTE = 4'b0001;

    typedef enum logic [2:0] {
        ST_MON    = 3'd0,
        ST_PLAY   = 3'd1,
        ST_BEEP1  = 3'd2,
        ST_REC    = 3'd3,
        ST_BEEP2  = 3'd4,
        ST_HANG   = 3'd5,
        ST_REMOTE = 3'd6
    } ctrl_state_e;

    typedef struct packed {
        ctrl_state_e st;
        logic        on_seen;
        logic        rs;
    } fsm_regs_t;

endpackage

// File: rtl/rec_timer.sv
module rec_timer #(
    parameter int REC_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int TW = $clog2(REC_LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(REC_LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: the seconds count restarts whenever recording is not active
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0));

endmodule

// File: rtl/msg_counter.sv
module msg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX) |=> (cnt_q == MAX));

    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(cnt_q));

endmodule

// File: rtl/call_fsm.sv
module call_fsm
    import call_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_done,
    input  logic              line_hangup,
    input  logic              machine_on,
    input  logic [TONE_W-1:0] tone_code,
    input  logic              sec_tick,
    input  logic              ann_done,
    input  logic              remote_done,
    input  logic              rec_expire,
    output logic              rec_run,
    output logic              msg_inc,
    output logic              off_hook,
    output logic              play_en,
    output logic              beep_en,
    output logic              rec_en,
    output logic              remote_start
);
    fsm_regs_t r_d, r_q;
    logic off_fall;
    logic remote_hit;

    always_comb begin
        off_fall   = r_q.on_seen & ~machine_on;
        remote_hit = (tone_code == TONE_REMOTE);
        r_d        = r_q;
        r_d.on_seen = machine_on;
        r_d.rs     = 1'b0;
        msg_inc    = 1'b0;
        if (r_q.st != ST_MON && off_fall) begin
            r_d.st = ST_MON;
        end else begin
            case (r_q.st)
                ST_MON: begin
                    if (ring_done && !line_hangup) r_d.st = ST_PLAY;
                end
                ST_PLAY: begin
                    if (remote_hit) begin
                        r_d.st = ST_REMOTE;
                        r_d.rs = 1'b1;
                    end else if (line_hangup) begin
                        r_d.st = ST_HANG;
                    end else if (ann_done) begin
                        r_d.st = ST_BEEP1;
                    end
                end
                ST_BEEP1: begin
                    if (remote_hit) begin
                        r_d.st = ST_REMOTE;
                        r_d.rs = 1'b1;
                    end else if (line_hangup) begin
                        r_d.st = ST_HANG;
                    end else if (sec_tick) begin
                        r_d.st = ST_REC;
                    end
                end
                ST_REC: begin
                    if (remote_hit) begin
                        r_d.st = ST_REMOTE;
                        r_d.rs = 1'b1;
                    end else if (line_hangup || rec_expire) begin
                        r_d.st = ST_BEEP2;
                    end
                end
                ST_BEEP2: begin
                    if (sec_tick) begin
                        r_d.st  = ST_HANG;
                        msg_inc = 1'b1;
                    end
                end
                ST_HANG:   r_d.st = ST_MON;
                ST_REMOTE: begin
                    if (remote_done) r_d.st = ST_HANG;
                end
                default:   r_d.st = ST_MON;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_MON;
            r_q.on_seen <= 1'b0;
            r_q.rs      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rec_run      = (r_q.st == ST_REC);
    assign play_en      = (r_q.st == ST_PLAY);
    assign rec_en       = (r_q.st == ST_REC);
    assign beep_en      = (r_q.st == ST_BEEP1) || (r_q.st == ST_BEEP2);
    assign off_hook     = (r_q.st != ST_MON) && (r_q.st != ST_HANG);
    assign remote_start = r_q.rs;

    assert_ring_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MON && ring_done && !line_hangup) |=> (r_q.st == ST_PLAY));

    assert_monitor_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MON && line_hangup) |=> (r_q.st == ST_MON));

    assert_hang_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HANG) |=> (r_q.st == ST_MON));

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remote_start |=> !remote_start);

    assert_remote_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PLAY && tone_code == TONE_REMOTE && line_hangup && machine_on)
        |=> (r_q.st == ST_REMOTE));

    assert_off_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_MON && r_q.on_seen && !machine_on) |=> (r_q.st == ST_MON));

endmodule

// File: rtl/call_ctrl.sv
module call_ctrl
    import call_ctrl_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int REC_LIMIT = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_done,
    input  logic              line_hangup,
    input  logic              machine_on,
    input  logic [TONE_W-1:0] tone_code,
    input  logic              sec_tick,
    input  logic              ann_done,
    input  logic              remote_done,
    output logic              off_hook,
    output logic              play_en,
    output logic              beep_en,
    output logic              rec_en,
    output logic              remote_start,
    output logic [CNT_W-1:0]  msg_count
);
    logic rec_run;
    logic rec_expire;
    logic msg_inc;

    call_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_done    (ring_done),
        .line_hangup  (line_hangup),
        .machine_on   (machine_on),
        .tone_code    (tone_code),
        .sec_tick     (sec_tick),
        .ann_done     (ann_done),
        .remote_done  (remote_done),
        .rec_expire   (rec_expire),
        .rec_run      (rec_run),
        .msg_inc      (msg_inc),
        .off_hook     (off_hook),
        .play_en      (play_en),
        .beep_en      (beep_en),
        .rec_en       (rec_en),
        .remote_start (remote_start)
    );

    rec_timer #(.REC_LIMIT(REC_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rec_run),
        .tick   (sec_tick),
        .expire (rec_expire)
    );

    msg_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (msg_inc),
        .count (msg_count)
    );

endmodule

// File: tb/call_ctrl_test.sv
module call_ctrl_test;
    localparam int CW  = 3;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_done = 0, line_hangup = 0, machine_on = 0;
    logic [3:0] tone_code = 4'd0;
    logic sec_tick = 0, ann_done = 0, remote_done = 0;
    logic off_hook, play_en, beep_en, rec_en, remote_start;
    logic [CW-1:0] msg_count;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_on = 0;
    bit finished = 0;

    // reference model state: phase 0 idle,1 ann,2 first beep,3 rec,4 last beep,5 hangup,6 remote
    int mph = 0, msecs = 0, mcnt = 0;
    bit mon_prev = 0, mrs = 0;

    always #2 clk = ~clk;

    call_ctrl #(.CNT_W(CW), .REC_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .ring_done(ring_done), .line_hangup(line_hangup),
        .machine_on(machine_on), .tone_code(tone_code), .sec_tick(sec_tick),
        .ann_done(ann_done), .remote_done(remote_done), .off_hook(off_hook),
        .play_en(play_en), .beep_en(beep_en), .rec_en(rec_en),
        .remote_start(remote_start), .msg_count(msg_count)
    );

    always @(posedge clk) begin : model
        int nph;
        bit fall, rem;
        if (!rst_n) begin
            mph = 0; msecs = 0; mcnt = 0; mon_prev = 0; mrs = 0;
        end else begin
            fall = mon_prev && !machine_on;
            rem  = (tone_code == 4'd1);
            nph  = mph;
            if (mph != 0 && fall) nph = 0;
            else if (mph == 0) begin
                if (ring_done && !line_hangup) nph = 1;
            end else if (mph == 1) begin
                if (rem) nph = 6; else if (line_hangup) nph = 5; else if (ann_done) nph = 2;
            end else if (mph == 2) begin
                if (rem) nph = 6; else if (line_hangup) nph = 5; else if (sec_tick) nph = 3;
            end else if (mph == 3) begin
                if (sec_tick) msecs++;
                if (rem) nph = 6; else if (line_hangup || msecs >= LIM) nph = 4;
            end else if (mph == 4) begin
                if (sec_tick) begin
                    nph = 5;
                    if (mcnt < (1 << CW) - 1) mcnt++;
                end
            end else if (mph == 5) nph = 0;
            else if (mph == 6) begin
                if (remote_done) nph = 5;
            end
            if (nph != 3) msecs = 0;
            mrs = (nph == 6 && mph != 6);
            mph = nph;
            mon_prev = machine_on;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(cur_req, "off_hook vs model", int'(off_hook), int'(mph != 0 && mph != 5));
            chk(cur_req, "play_en vs model", int'(play_en), int'(mph == 1));
            chk(cur_req, "beep_en vs model", int'(beep_en), int'(mph == 2 || mph == 4));
            chk(cur_req, "rec_en vs model", int'(rec_en), int'(mph == 3));
            chk(cur_req, "remote_start vs model", int'(remote_start), int'(mrs));
            chk(cur_req, "msg_count vs model", int'(msg_count), mcnt);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic p_ring();   ring_done = 1;   @(negedge clk); ring_done = 0;   endtask
    task automatic p_tick();   sec_tick = 1;    @(negedge clk); sec_tick = 0;    endtask
    task automatic p_ann();    ann_done = 1;    @(negedge clk); ann_done = 0;    endtask
    task automatic p_rdone();  remote_done = 1; @(negedge clk); remote_done = 0; endtask
    task automatic p_hang();   line_hangup = 1; @(negedge clk); line_hangup = 0; endtask
    task automatic to_rec();   p_ring(); p_ann(); p_tick(); endtask
    task automatic full_call(); to_rec(); idle(2); p_hang(); p_tick(); idle(1); endtask

    initial begin : watchdog
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL R4 watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        machine_on = 1;
        idle(3);
        rst_n = 1;
        cmp_on = 1;
        cur_req = "R1";
        idle(1);
        chk("R1", "off_hook after reset", int'(off_hook), 0);
        chk("R1", "enables after reset", int'({play_en, beep_en, rec_en, remote_start}), 0);
        chk("R1", "msg_count after reset", int'(msg_count), 0);

        cur_req = "R2";
        p_ring();
        chk("R2", "play_en after ring", int'(play_en), 1);
        chk("R2", "off_hook after ring", int'(off_hook), 1);
        cur_req = "R4";
        p_ann();
        chk("R4", "beep after announcement", int'(beep_en), 1);
        p_tick();
        chk("R4", "rec after beep", int'(rec_en), 1);
        idle(2);
        p_hang();
        chk("R4", "closing beep after hangup", int'(beep_en), 1);
        p_tick();
        chk("R4", "hang step on-hook", int'(off_hook), 0);
        chk("R9", "count after call", int'(msg_count), 1);
        idle(1);
        chk("R4", "monitor after hang step", int'(off_hook), 0);

        cur_req = "R11";
        to_rec();
        for (int i = 0; i < LIM - 1; i++) p_tick();
        chk("R11", "still recording before limit", int'(rec_en), 1);
        p_tick();
        chk("R11", "beep at limit", int'(beep_en), 1);
        p_tick(); idle(1);
        chk("R11", "count after limit call", int'(msg_count), 2);

        cur_req = "R3";
        line_hangup = 1; p_ring(); line_hangup = 0;
        chk("R3", "ring with hangup ignored", int'(off_hook), 0);
        idle(1);
        chk("R3", "still monitoring", int'(play_en), 0);

        cur_req = "R5";
        p_ring(); idle(1);
        p_hang();
        chk("R5", "hangup in announcement", int'(off_hook), 0);
        chk("R5", "no beep", int'(beep_en), 0);
        idle(2);
        chk("R5", "count unchanged", int'(msg_count), 2);

        cur_req = "R6";
        p_ring();
        tone_code = 4'd2; idle(1); tone_code = 4'd0;
        chk("R6", "wrong code ignored", int'(play_en), 1);
        tone_code = 4'd1; idle(1); tone_code = 4'd0;
        chk("R6", "remote_start pulse", int'(remote_start), 1);
        chk("R6", "off-hook in remote", int'(off_hook), 1);
        idle(1);
        chk("R6", "remote_start single cycle", int'(remote_start), 0);
        p_rdone();
        chk("R6", "hang step after remote", int'(off_hook), 0);
        idle(1);
        to_rec();
        tone_code = 4'd1; idle(1); tone_code = 4'd0;
        chk("R6", "remote from recording", int'(remote_start), 1);
        p_rdone(); idle(1);

        cur_req = "R7";
        p_ring();
        tone_code = 4'd1; line_hangup = 1; idle(1); tone_code = 4'd0; line_hangup = 0;
        chk("R7", "remote beats hangup", int'(remote_start), 1);

        cur_req = "R8";
        idle(2);
        machine_on = 0; idle(1);
        chk("R8", "off during remote", int'(off_hook), 0);
        machine_on = 1; idle(1);
        to_rec();
        machine_on = 0; idle(1);
        chk("R8", "off during recording", int'(off_hook), 0);
        chk("R8", "no count on abort", int'(msg_count), 2);
        machine_on = 1; idle(2);

        cur_req = "R9";
        p_ring(); p_ann();
        p_hang();
        chk("R9", "hangup in first beep", int'(off_hook), 0);
        idle(1);
        chk("R9", "no count from first beep", int'(msg_count), 2);
        to_rec(); p_hang();
        line_hangup = 1; idle(2); line_hangup = 0;
        chk("R9", "hangup in closing beep ignored", int'(beep_en), 1);
        p_tick(); idle(1);
        chk("R9", "count after closing beep", int'(msg_count), 3);

        cur_req = "R10";
        for (int i = 0; i < 6; i++) full_call();
        chk("R10", "count saturates", int'(msg_count), 7);

        cmp_on = 0;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule